// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog whose down-counter runs from a slow clock that is independent of the bus. Software talks to it through four bus registers: a key register, a prescaler register, a reload register and a status register. Special values written to the key register open the configuration registers for writing, start the watchdog, or refresh the counter. When software stops refreshing and the counter runs out, the block sends a one-cycle reset request in the slow clock domain.

Configuration written on the bus is copied into the slow domain by a toggle handshake. The status register shows a busy bit for each configuration register until its new value has reached the counter. Firmware writes the unlock key, writes the divider and reload values, polls status until both busy bits are clear, and then writes the start key. After that it writes the refresh key periodically, more often than the timeout. Once started, the watchdog cannot be stopped.

Top module: `key_watchdog`

## Requirements
- R1: After reset the prescaler field reads 0, the reload field reads 0xFFF, status reads 0 and `wdg_rst_req` is low.
- R2: Address 0 is the key register and reads as 0. Address 1 holds the prescaler field in its low bits. Address 2 holds the 12-bit reload value. Address 3 is status, with bit 0 the prescaler busy flag and bit 1 the reload busy flag.
- R3: Key 0x5555 opens write access. Key 0x0000, or any value other than 0x5555, 0xCCCC and 0xAAAA, closes it. Keys 0xCCCC and 0xAAAA leave the access state as it is.
- R4: A write to the prescaler or reload register while access is closed leaves the stored value unchanged.
- R5: A prescaler field value p divides the slow clock by 4·2^p. A value above the largest allowed field (6 when the largest divider is 256) is stored as that largest field.
- R6: An accepted prescaler or reload write sets its status busy bit on the next bus cycle. The bit clears by itself within 40 bus cycles. A write to a register whose busy bit is set is ignored.
- R7: Until key 0xCCCC has been written, `wdg_rst_req` stays low.
- R8: Once the watchdog is running, reset requests are one slow cycle wide and are spaced exactly (reload+1)·divider slow cycles apart.
- R9: Key 0xAAAA reloads the counter. Refreshes written more often than the timeout keep `wdg_rst_req` low.
- R10: Once started, the watchdog keeps running whatever keys are written afterwards.
- R11: A prescaler value written while the watchdog is running sets the request spacing once it has reached the slow domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, bus domain |
| slow_clk | input | 1 | Independent slow counting clock |
| slow_rst_n | input | 1 | Active-low reset, slow domain |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| wdg_rst_req | output | 1 | One-slow-cycle reset request (slow domain) |

## Verification
If the divider or counter holds a wrong value, the spacing between reset requests comes out wrong, and that shows up within one timeout period. It also shows when a request appears during an idle or refreshed window, where no request should come at all. A handshake toggle stuck in the wrong phase shows up at once as a busy bit that never clears, or as a register that rejects writes. A lock bit with a wrong value shows up on the very next read-back of a configuration register.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam logic [15:0] KEY_UNLOCK = 16'h5555;
    localparam logic [15:0] KEY_LOCK   = 16'h0000;
    localparam logic [15:0] KEY_START  = 16'hCCCC;
    localparam logic [15:0] KEY_KICK   = 16'hAAAA;

    typedef enum logic [1:0] {
        ADDR_KEY    = 2'd0,
        ADDR_PRESC  = 2'd1,
        ADDR_RELOAD = 2'd2,
        ADDR_STATUS = 2'd3
    } wdg_addr_e;

    typedef enum logic [1:0] {
        ACT_UNLOCK,
        ACT_RELOCK,
        ACT_START,
        ACT_KICK
    } key_act_e;

    function automatic key_act_e decode_key(input logic [15:0] key);
        key_act_e act;
        case (key)
            KEY_UNLOCK: act = ACT_UNLOCK;
            KEY_START:  act = ACT_START;
            KEY_KICK:   act = ACT_KICK;
            default:    act = ACT_RELOCK; // KEY_LOCK and every unknown key
        endcase
        return act;
    endfunction

endpackage

// File: rtl/wdg_sync2.sv
module wdg_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.meta = d;
        st_d.sync = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.sync;
endmodule

// File: rtl/wdg_bus_regs.sv
module wdg_bus_regs
    import wdg_pkg::*;
#(
    parameter int PR_W   = 3,
    parameter int PR_MAX = 6,
    parameter int RL_W   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [15:0]     wdata,
    output logic [15:0]     rdata,
    output logic [PR_W-1:0] presc_o,
    output logic [RL_W-1:0] reload_o,
    output logic            presc_tgl_o,
    output logic            reload_tgl_o,
    output logic            start_o,
    output logic            kick_tgl_o,
    input  logic            presc_ack_i,
    input  logic            reload_ack_i
);
    localparam logic [PR_W-1:0] PR_TOP = PR_W'(PR_MAX);
    localparam logic [RL_W-1:0] RL_RST = '1;

    typedef struct packed {
        logic            unlocked;
        logic [PR_W-1:0] presc;
        logic [RL_W-1:0] reload;
        logic            presc_tgl;
        logic            reload_tgl;
        logic            start;
        logic            kick_tgl;
    } bus_st_t;

    bus_st_t         st_d, st_q;
    wdg_addr_e       sel;
    key_act_e        act;
    logic            presc_busy, reload_busy;
    logic [PR_W-1:0] pr_wr;

    assign sel         = wdg_addr_e'(addr);
    assign act         = decode_key(wdata);
    assign presc_busy  = st_q.presc_tgl ^ presc_ack_i;
    assign reload_busy = st_q.reload_tgl ^ reload_ack_i;
    assign pr_wr       = (wdata[PR_W-1:0] > PR_TOP) ? PR_TOP : wdata[PR_W-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                ADDR_KEY: begin
                    case (act)
                        ACT_UNLOCK: st_d.unlocked = 1'b1;
                        ACT_START:  st_d.start    = 1'b1;
                        ACT_KICK:   st_d.kick_tgl = ~st_q.kick_tgl;
                        default:    st_d.unlocked = 1'b0;
                    endcase
                end
                ADDR_PRESC: begin
                    if (st_q.unlocked && !presc_busy) begin
                        st_d.presc     = pr_wr;
                        st_d.presc_tgl = ~st_q.presc_tgl;
                    end
                end
                ADDR_RELOAD: begin
                    if (st_q.unlocked && !reload_busy) begin
                        st_d.reload     = wdata[RL_W-1:0];
                        st_d.reload_tgl = ~st_q.reload_tgl;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{unlocked: 1'b0, presc: '0, reload: RL_RST, presc_tgl: 1'b0,
                      reload_tgl: 1'b0, start: 1'b0, kick_tgl: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel)
            ADDR_PRESC:  rdata = 16'(st_q.presc);
            ADDR_RELOAD: rdata = 16'(st_q.reload);
            ADDR_STATUS: rdata = {14'd0, reload_busy, presc_busy};
            default:     rdata = 16'd0;
        endcase
    end

    assign presc_o      = st_q.presc;
    assign reload_o     = st_q.reload;
    assign presc_tgl_o  = st_q.presc_tgl;
    assign reload_tgl_o = st_q.reload_tgl;
    assign start_o      = st_q.start;
    assign kick_tgl_o   = st_q.kick_tgl;

    AST_LOCKED_PR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == ADDR_PRESC && !st_q.unlocked) |=> $stable(st_q.presc)); // R4
    AST_LOCKED_RL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == ADDR_RELOAD && !st_q.unlocked) |=> $stable(st_q.reload)); // R4
    AST_PR_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == ADDR_PRESC && st_q.unlocked && !presc_busy) |=> presc_busy); // R6
    AST_RL_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == ADDR_RELOAD && st_q.unlocked && !reload_busy) |=> reload_busy); // R6
    AST_PR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.presc <= PR_TOP); // R5
    AST_START_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |=> st_q.start); // R10
endmodule

// File: rtl/wdg_slow_core.sv
module wdg_slow_core #(
    parameter int PR_W  = 3,
    parameter int RL_W  = 12,
    parameter int DIV_W = 8
) (
    input  logic            slow_clk,
    input  logic            slow_rst_n,
    input  logic            presc_req_i,
    input  logic            reload_req_i,
    input  logic            start_i,
    input  logic            kick_req_i,
    input  logic [PR_W-1:0] presc_i,
    input  logic [RL_W-1:0] reload_i,
    output logic            presc_ack_o,
    output logic            reload_ack_o,
    output logic            fire_o
);
    localparam logic [RL_W-1:0] RL_RST = '1;

    typedef struct packed {
        logic             presc_seen;
        logic             reload_seen;
        logic             kick_seen;
        logic             running;
        logic [PR_W-1:0]  presc;
        logic [RL_W-1:0]  reload;
        logic [DIV_W-1:0] div_cnt;
        logic [RL_W-1:0]  cnt;
        logic             fire;
    } core_st_t;

    core_st_t         st_d, st_q;
    logic [DIV_W:0]   div_span;
    logic [DIV_W-1:0] div_lim;
    logic             kick_evt;

    assign div_span = (DIV_W + 1)'(4) << st_q.presc;
    assign div_lim  = div_span[DIV_W-1:0] - DIV_W'(1);
    assign kick_evt = kick_req_i ^ st_q.kick_seen;

    always_comb begin
        st_d           = st_q;
        st_d.fire      = 1'b0;
        st_d.kick_seen = kick_req_i;
        if (presc_req_i != st_q.presc_seen) begin
            st_d.presc_seen = presc_req_i;
            st_d.presc      = presc_i;
        end
        if (reload_req_i != st_q.reload_seen) begin
            st_d.reload_seen = reload_req_i;
            st_d.reload      = reload_i;
        end
        if (!st_q.running) begin
            if (start_i) begin
                st_d.running = 1'b1;
                st_d.cnt     = st_q.reload;
                st_d.div_cnt = '0;
            end
        end else if (kick_evt) begin
            st_d.cnt     = st_q.reload;
            st_d.div_cnt = '0;
        end else if (st_q.div_cnt >= div_lim) begin
            st_d.div_cnt = '0;
            if (st_q.cnt == '0) begin
                st_d.fire = 1'b1;
                st_d.cnt  = st_q.reload;
            end else begin
                st_d.cnt = st_q.cnt - RL_W'(1);
            end
        end else begin
            st_d.div_cnt = st_q.div_cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge slow_clk or negedge slow_rst_n) begin
        if (!slow_rst_n) begin
            st_q <= '{presc_seen: 1'b0, reload_seen: 1'b0, kick_seen: 1'b0, running: 1'b0,
                      presc: '0, reload: RL_RST, div_cnt: '0, cnt: RL_RST, fire: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign presc_ack_o  = st_q.presc_seen;
    assign reload_ack_o = st_q.reload_seen;
    assign fire_o       = st_q.fire;

    AST_FIRE_SINGLE: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        st_q.fire |=> !st_q.fire); // R8
    AST_IDLE_QUIET: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        !st_q.running |-> !st_q.fire); // R7
    AST_RUN_STICKY: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        st_q.running |=> st_q.running); // R10
    AST_KICK_RELOAD: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        (st_q.running && kick_evt) |=> (st_q.div_cnt == '0 && !st_q.fire)); // R9
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog #(
    parameter int MAX_DIV_LOG2 = 8,
    parameter int RELOAD_W     = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_clk,
    input  logic        slow_rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        wdg_rst_req
);
    localparam int PR_MAX = MAX_DIV_LOG2 - 2;
    localparam int PR_W   = $clog2(PR_MAX + 1);

    generate
        if (MAX_DIV_LOG2 != 8 && MAX_DIV_LOG2 != 10) begin : g_bad_div
            $error("key_watchdog: MAX_DIV_LOG2 must be 8 or 10");
        end
    endgenerate

    logic [PR_W-1:0]     presc_b;
    logic [RELOAD_W-1:0] reload_b;
    logic                presc_tgl_b, reload_tgl_b, start_b, kick_tgl_b;
    logic [3:0]          to_slow_s;
    logic                presc_ack_s, reload_ack_s;
    logic [1:0]          ack_b;

    wdg_bus_regs #(
        .PR_W   (PR_W),
        .PR_MAX (PR_MAX),
        .RL_W   (RELOAD_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .presc_o      (presc_b),
        .reload_o     (reload_b),
        .presc_tgl_o  (presc_tgl_b),
        .reload_tgl_o (reload_tgl_b),
        .start_o      (start_b),
        .kick_tgl_o   (kick_tgl_b),
        .presc_ack_i  (ack_b[0]),
        .reload_ack_i (ack_b[1])
    );

    wdg_sync2 #(.W(4)) u_to_slow (
        .clk   (slow_clk),
        .rst_n (slow_rst_n),
        .d     ({kick_tgl_b, start_b, reload_tgl_b, presc_tgl_b}),
        .q     (to_slow_s)
    );

    wdg_slow_core #(
        .PR_W  (PR_W),
        .RL_W  (RELOAD_W),
        .DIV_W (MAX_DIV_LOG2)
    ) u_core (
        .slow_clk     (slow_clk),
        .slow_rst_n   (slow_rst_n),
        .presc_req_i  (to_slow_s[0]),
        .reload_req_i (to_slow_s[1]),
        .start_i      (to_slow_s[2]),
        .kick_req_i   (to_slow_s[3]),
        .presc_i      (presc_b),
        .reload_i     (reload_b),
        .presc_ack_o  (presc_ack_s),
        .reload_ack_o (reload_ack_s),
        .fire_o       (wdg_rst_req)
    );

    wdg_sync2 #(.W(2)) u_to_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({reload_ack_s, presc_ack_s}),
        .q     (ack_b)
    );
endmodule

// File: tb/tb_key_watchdog.sv
module tb_key_watchdog;
    logic        clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        wdg_rst_req;

    key_watchdog dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_clk    (slow_clk),
        .slow_rst_n  (slow_rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .wdg_rst_req (wdg_rst_req)
    );

    always #2 clk = ~clk;        // 250 MHz bus clock
    always #6 slow_clk = ~slow_clk;

    int total_i = 0, bad_i = 0;
    int total_s = 0, bad_s = 0;
    int period_checks = 0, pulse_cnt = 0;
    int exp_period = 0, arm_gen = 0;
    bit chk_en = 1'b0, quiet = 1'b0;
    string period_tag = "R8", quiet_tag = "R7";
    int cyc = 0;

    // slow-domain reference: expected request spacing, width and silence
    int  since = 0, skip_n = 0, seen_gen = 0;
    bit  prev_req = 1'b0;
    always @(negedge slow_clk) begin
        if (slow_rst_n) begin
            if (arm_gen != seen_gen) begin
                seen_gen = arm_gen;
                skip_n   = 2;
            end
            if (quiet) begin
                total_s++;
                if (wdg_rst_req) begin
                    bad_s++;
                    $display("FAIL %s request during silent window act=1 exp=0", quiet_tag);
                end
            end
            if (wdg_rst_req) begin
                pulse_cnt++;
                total_s++;
                if (prev_req) begin
                    bad_s++;
                    $display("FAIL R8 request wider than one slow cycle act=2 exp=1");
                end
                if (chk_en && skip_n == 0) begin
                    total_s++;
                    period_checks++;
                    if (since + 1 != exp_period) begin
                        bad_s++;
                        $display("FAIL %s spacing act=%0d exp=%0d", period_tag, since + 1, exp_period);
                    end
                end else if (skip_n > 0) begin
                    skip_n--;
                end
                since = 0;
            end else begin
                since++;
            end
            prev_req = wdg_rst_req;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog expired act=%0d exp<150000", cyc);
            $display("test done: total=%0d bad=%0d", total_i + total_s + 1, bad_i + bad_s + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total_i++;
        if (!ok) begin
            bad_i++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic wait_idle(input string tag);
        int v = 1;
        for (int i = 0; i < 40 && v != 0; i++) bus_rd(2'd3, v);
        chk(v == 0, tag, v, 0);
    endtask

    task automatic wait_checks(input int n, input string tag);
        int target = period_checks + n;
        for (int i = 0; i < 20000 && period_checks < target; i++) @(negedge clk);
        chk(period_checks >= target, tag, period_checks, target);
    endtask

    task automatic arm(input int rl, input int pr, input string tag);
        exp_period = (rl + 1) * (4 << pr);
        period_tag = tag;
        chk_en     = 1'b1;
        arm_gen++;
    endtask

    initial begin
        int v;
        repeat (10) @(negedge clk);
        rst_n      = 1'b1;
        slow_rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(2'd1, v); chk(v == 0, "R1 prescaler reset", v, 0);
        bus_rd(2'd2, v); chk(v == 'hFFF, "R1 reload reset", v, 'hFFF);
        bus_rd(2'd3, v); chk(v == 0, "R1 status reset", v, 0);
        chk(wdg_rst_req == 1'b0, "R1 request low", int'(wdg_rst_req), 0);
        // R2 key register reads zero
        bus_wr(2'd0, 16'h1234);
        bus_rd(2'd0, v); chk(v == 0, "R2 key reads zero", v, 0);

        // R4 locked writes ignored
        bus_wr(2'd1, 16'd3);
        bus_rd(2'd1, v); chk(v == 0, "R4 locked prescaler", v, 0);
        bus_wr(2'd2, 16'd7);
        bus_rd(2'd2, v); chk(v == 'hFFF, "R4 locked reload", v, 'hFFF);

        // R3 unlock, R6 busy behaviour
        bus_wr(2'd0, 16'h5555);
        bus_wr(2'd1, 16'd2);
        bus_rd(2'd3, v); chk(v == 1, "R6 prescaler busy set", v, 1);
        bus_wr(2'd1, 16'd1);
        bus_rd(2'd1, v); chk(v == 2, "R6 write while busy ignored", v, 2);
        wait_idle("R6 prescaler busy clears");
        bus_rd(2'd1, v); chk(v == 2, "R3 unlocked prescaler write", v, 2);
        bus_wr(2'd2, 16'd5);
        bus_rd(2'd3, v); chk(v == 2, "R6 reload busy set on bit1", v, 2);
        wait_idle("R6 reload busy clears");
        bus_rd(2'd2, v); chk(v == 5, "R2 reload read-back", v, 5);

        // R5 clamp above largest field
        bus_wr(2'd1, 16'd7);
        wait_idle("R6 clear after clamp write");
        bus_rd(2'd1, v); chk(v == 6, "R5 prescaler clamp", v, 6);

        // R3 relock with 0x0000, kick keeps lock state, unknown key relocks
        bus_wr(2'd0, 16'h0000);
        bus_wr(2'd1, 16'd3);
        bus_rd(2'd1, v); chk(v == 6, "R3 locked by 0x0000", v, 6);
        bus_wr(2'd0, 16'h5555);
        bus_wr(2'd0, 16'hAAAA);
        bus_wr(2'd1, 16'd1);
        wait_idle("R6 clear after kick test");
        bus_rd(2'd1, v); chk(v == 1, "R3 refresh key keeps access", v, 1);
        bus_wr(2'd0, 16'h1234);
        bus_wr(2'd1, 16'd2);
        bus_rd(2'd1, v); chk(v == 1, "R3 unknown key relocks", v, 1);
        bus_wr(2'd0, 16'h5555);
        bus_wr(2'd1, 16'd0);
        wait_idle("R6 clear before start");

        // R7 no request before start
        quiet_tag = "R7";
        quiet = 1'b1;
        repeat (200) @(negedge clk);
        quiet = 1'b0;

        // R8 start, spacing (5+1)*4 = 24 slow cycles
        bus_wr(2'd0, 16'hCCCC);
        arm(5, 0, "R8");
        wait_checks(4, "R8 periodic requests");

        // R10 keys cannot stop it
        bus_wr(2'd0, 16'h0000);
        bus_wr(2'd0, 16'h1234);
        bus_wr(2'd0, 16'h5555);
        wait_checks(3, "R10 keeps running after keys");

        // R11 live prescaler change, spacing (5+1)*8 = 48
        bus_wr(2'd1, 16'd1);
        wait_idle("R6 clear while running");
        arm(5, 1, "R11");
        wait_checks(3, "R11 new divider in effect");

        // R9 refresh keeps it silent
        begin
            int n = pulse_cnt;
            for (int i = 0; i < 5000 && pulse_cnt == n; i++) @(negedge clk);
        end
        chk_en    = 1'b0;
        quiet_tag = "R9";
        bus_wr(2'd0, 16'hAAAA);
        quiet = 1'b1;
        for (int i = 0; i < 15; i++) begin
            repeat (20) @(negedge clk);
            bus_wr(2'd0, 16'hAAAA);
        end
        quiet = 1'b0;
        arm(5, 1, "R9");
        wait_checks(2, "R9 requests resume after refresh stops");

        $display("test done: total=%0d bad=%0d", total_i + total_s, bad_i + bad_s);
        $finish;
    end
endmodule